// File: doc/BRIEF.md
# Clock Ratio Detector and Word-Clock Sync Monitor

This block sits on the system clock of an audio converter's digital section. It measures the length of every word-clock period in system-clock cycles and decides whether the system clock runs at 256, 384 or 512 times the sample rate. Once that ratio is settled, it issues a clock enable that fires exactly 256 times per sample period. The filter and modulator timing downstream runs on this enable, whatever the incoming ratio is.

The block also counts bit-clock rising edges in each word-clock period and compares each count with the one before. A jump larger than the allowed drift counts as lost synchronization, and so does a word-clock period that no longer matches the settled ratio. When synchronization is lost, the block drops its sync flag and asks the output path to mute. Once the clocks agree again, the mute request is held for a fixed number of further word-clock periods before normal data may flow. The word clock and the bit clock are sampled levels that must be synchronous to the system clock. No particular phase between them is needed.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: While reset is high, `ratio_code` is 2'b11, `en_256` is 0, `sync_ok` is 0 and `mute_req` is 1.
- R2: A word-clock period is measured between rising edges of `wclk`. A period within ±TOL (2) system clocks of 256, 384 or 512 is classed as code 2'b00, 2'b01 or 2'b10. A code is reported only when two consecutive periods give the same class and differ by at most TOL cycles. Every other case reports 2'b11. A period of 258 still counts as 256, while 259 is never accepted.
- R3: After reset, the first valid code appears at the third `wclk` rising edge. After only two rising edges, the code is still 2'b11.
- R4: While a ratio is reported, `en_256` is high on exactly 256 cycles of each word-clock period. At ratio 256 it is high on every cycle.
- R5: At ratio 512, `en_256` is high on every second system-clock cycle.
- R6: At ratio 384, the gaps between `en_256` pulses alternate between one and two cycles, and no gap is longer than two.
- R7: While `ratio_code` is 2'b11, `en_256` stays low.
- R8: If the bit-clock edge count of a word-clock period differs by at most DRIFT_MAX (6) from the count of the previous period, `sync_ok` and `mute_req` do not change.
- R9: A difference larger than DRIFT_MAX makes `sync_ok` fall and `mute_req` rise at the `wclk` rising edge that closes the offending period.
- R10: A word-clock period that breaks the settled ratio drops `ratio_code` to 2'b11 and drops `sync_ok`. A steady new ratio is reported after two matching periods.
- R11: `sync_ok` rises at the edge where the clocks become consistent, with `mute_req` still high. `mute_req` falls at the 32nd (MUTE_FRAMES) `wclk` rising edge after that.
- R12: `mute_req` is never low while `sync_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk | input | 1 | Word clock level, synchronous to `clk` |
| bclk | input | 1 | Bit clock level, synchronous to `clk` |
| ratio_code | output | 2 | 00 = 256x, 01 = 384x, 10 = 512x, 11 = not locked |
| en_256 | output | 1 | Clock enable at 256 times the sample rate |
| sync_ok | output | 1 | Word clock and system clock are consistent |
| mute_req | output | 1 | Request to force output data to zero |

## Verification
Word-clock periods of 256, 384 and 512 cycles are applied after a reset. These show that each ratio class is decoded and that each gives its own enable spacing (every cycle, 1-2 alternation, every other cycle) while the count per period stays at 256. Periods of 258 and 259 bracket the acceptance window. A single 300-cycle period and a live switch from 256 to 512 separate a loss of lock from a relock at a new ratio. Bit-clock counts raised by 4, 6 and 7 edges separate tolerated drift from a sync loss, and the 32-period mute window is checked period by period, both after the first acquisition and after a drift-induced resync.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;

    localparam int unsigned PERIOD_W = 12;  // system clocks per word period
    localparam int unsigned BITS_W   = 9;   // bit-clock edges per word period

    typedef enum logic [1:0] {
        RATIO_256  = 2'b00,
        RATIO_384  = 2'b01,
        RATIO_512  = 2'b10,
        RATIO_NONE = 2'b11
    } ratio_e;

    typedef enum logic [1:0] {
        SYNC_HUNT   = 2'b00,
        SYNC_SETTLE = 2'b01,
        SYNC_RUN    = 2'b10
    } sync_state_e;

    // Result of one word-clock period, valid while frame_tick is high
    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [BITS_W-1:0]   bits;
        logic [BITS_W-1:0]   prev_bits;
        logic                have_prev;
    } frame_meas_t;

    function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic ratio_e classify(input int unsigned period,
                                        input int unsigned base,
                                        input int unsigned tol);
        ratio_e r;
        r = RATIO_NONE;
        if (abs_diff(period, base) <= tol)
            r = RATIO_256;
        else if (abs_diff(period, base + base / 2) <= tol)
            r = RATIO_384;
        else if (abs_diff(period, 2 * base) <= tol)
            r = RATIO_512;
        return r;
    endfunction

endpackage

// File: rtl/crs_frame_meter.sv
`timescale 1ns/1ps
module crs_frame_meter
    import crs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wclk,
    input  logic        bclk,
    output logic        frame_rise,
    output logic        frame_tick,
    output frame_meas_t meas
);

    localparam logic [PERIOD_W-1:0] PERIOD_MAX = {PERIOD_W{1'b1}};
    localparam logic [BITS_W-1:0]   BITS_MAX   = {BITS_W{1'b1}};

    logic                wclk_r, wclk_rr;
    logic                bclk_r, bclk_rr;
    logic                started;
    logic                meas_valid;
    logic                bit_rise;
    logic [PERIOD_W-1:0] cyc;
    logic [BITS_W-1:0]   bit_cnt;
    logic [BITS_W-1:0]   bit_next;

    assign frame_rise = wclk_r & ~wclk_rr;
    assign bit_rise   = bclk_r & ~bclk_rr;
    assign bit_next   = (bit_cnt == BITS_MAX) ? bit_cnt
                                              : bit_cnt + {{(BITS_W-1){1'b0}}, bit_rise};

    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_r     <= 1'b0;
            wclk_rr    <= 1'b0;
            bclk_r     <= 1'b0;
            bclk_rr    <= 1'b0;
            started    <= 1'b0;
            meas_valid <= 1'b0;
            frame_tick <= 1'b0;
            cyc        <= '0;
            bit_cnt    <= '0;
            meas       <= '0;
        end else begin
            wclk_r     <= wclk;
            wclk_rr    <= wclk_r;
            bclk_r     <= bclk;
            bclk_rr    <= bclk_r;
            frame_tick <= frame_rise & started;
            if (frame_rise) begin
                started        <= 1'b1;
                meas_valid     <= started;
                cyc            <= {{(PERIOD_W-1){1'b0}}, 1'b1};
                bit_cnt        <= '0;
                meas.period    <= cyc;
                meas.bits      <= bit_next;
                meas.prev_bits <= meas.bits;
                meas.have_prev <= meas_valid;
            end else begin
                cyc     <= (cyc == PERIOD_MAX) ? cyc : cyc + 1'b1;
                bit_cnt <= bit_next;
            end
        end
    end

endmodule

// File: rtl/crs_ratio_lock.sv
`timescale 1ns/1ps
module crs_ratio_lock
    import crs_pkg::*;
#(
    parameter int unsigned BASE = 256,
    parameter int unsigned TOL  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_tick,
    input  frame_meas_t meas,
    output logic        match,
    output ratio_e      ratio
);

    ratio_e              cls_now;
    ratio_e              prev_cls;
    logic [PERIOD_W-1:0] prev_period;
    logic                prev_valid;

    assign cls_now = classify(32'(meas.period), BASE, TOL);
    assign match   = prev_valid && (cls_now != RATIO_NONE) && (cls_now == prev_cls)
                     && (abs_diff(32'(meas.period), 32'(prev_period)) <= TOL);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid  <= 1'b0;
            prev_cls    <= RATIO_NONE;
            prev_period <= '0;
            ratio       <= RATIO_NONE;
        end else if (frame_tick) begin
            prev_valid  <= 1'b1;
            prev_cls    <= cls_now;
            prev_period <= meas.period;
            ratio       <= match ? cls_now : RATIO_NONE;
        end
    end

endmodule

// File: rtl/crs_rate_enable.sv
`timescale 1ns/1ps
module crs_rate_enable
    import crs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_rise,
    input  ratio_e ratio,
    output logic   en
);

    logic [1:0] ph;
    logic       wrap;

    // 384x runs a modulo-3 phase, 512x a modulo-2 phase
    assign wrap = (ph == 2'd2) || ((ratio == RATIO_512) && (ph == 2'd1));

    always_ff @(posedge clk) begin
        if (rst || frame_rise)
            ph <= 2'd0;
        else
            ph <= wrap ? 2'd0 : ph + 2'd1;
    end

    always_comb begin
        unique case (ratio)
            RATIO_256: en = 1'b1;
            RATIO_384: en = (ph != 2'd2);
            RATIO_512: en = (ph == 2'd0);
            default:   en = 1'b0;
        endcase
    end

endmodule

// File: rtl/crs_sync_seq.sv
`timescale 1ns/1ps
module crs_sync_seq
    import crs_pkg::*;
#(
    parameter int unsigned DRIFT_MAX   = 6,
    parameter int unsigned MUTE_FRAMES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_tick,
    input  logic        match,
    input  frame_meas_t meas,
    output logic        sync_ok,
    output logic        mute_req
);

    localparam int unsigned HW = $clog2(MUTE_FRAMES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(MUTE_FRAMES - 1);

    sync_state_e   state;
    logic [HW-1:0] hold_cnt;
    logic          drift_bad;
    logic          loss;

    assign drift_bad = meas.have_prev &&
                       (abs_diff(32'(meas.bits), 32'(meas.prev_bits)) > DRIFT_MAX);
    assign loss      = !match || drift_bad;
    assign sync_ok   = (state != SYNC_HUNT);
    assign mute_req  = (state != SYNC_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SYNC_HUNT;
            hold_cnt <= '0;
        end else if (frame_tick) begin
            unique case (state)
                SYNC_HUNT: begin
                    if (!loss) begin
                        state    <= SYNC_SETTLE;
                        hold_cnt <= '0;
                    end
                end
                SYNC_SETTLE: begin
                    if (loss)
                        state <= SYNC_HUNT;
                    else if (hold_cnt == HOLD_LAST)
                        state <= SYNC_RUN;
                    else
                        hold_cnt <= hold_cnt + 1'b1;
                end
                default: begin
                    if (loss)
                        state <= SYNC_HUNT;
                end
            endcase
        end
    end

endmodule

// File: rtl/clk_ratio_sync_mon.sv
`timescale 1ns/1ps
module clk_ratio_sync_mon
    import crs_pkg::*;
#(
    parameter int unsigned BASE        = 256,
    parameter int unsigned TOL         = 2,
    parameter int unsigned DRIFT_MAX   = 6,
    parameter int unsigned MUTE_FRAMES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wclk,
    input  logic       bclk,
    output logic [1:0] ratio_code,
    output logic       en_256,
    output logic       sync_ok,
    output logic       mute_req
);

    logic        frame_rise;
    logic        frame_tick;
    logic        match;
    frame_meas_t meas;
    ratio_e      ratio;

    crs_frame_meter u_meter (
        .clk        (clk),
        .rst        (rst),
        .wclk       (wclk),
        .bclk       (bclk),
        .frame_rise (frame_rise),
        .frame_tick (frame_tick),
        .meas       (meas)
    );

    crs_ratio_lock #(.BASE(BASE), .TOL(TOL)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .meas       (meas),
        .match      (match),
        .ratio      (ratio)
    );

    crs_rate_enable u_enable (
        .clk        (clk),
        .rst        (rst),
        .frame_rise (frame_rise),
        .ratio      (ratio),
        .en         (en_256)
    );

    crs_sync_seq #(.DRIFT_MAX(DRIFT_MAX), .MUTE_FRAMES(MUTE_FRAMES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .match      (match),
        .meas       (meas),
        .sync_ok    (sync_ok),
        .mute_req   (mute_req)
    );

    assign ratio_code = ratio;

endmodule

// File: rtl/crs_checker.sv
`timescale 1ns/1ps
module crs_checker #(
    parameter int unsigned MUTE_FRAMES = 32
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ratio_code,
    input logic       en_256,
    input logic       sync_ok,
    input logic       mute_req,
    input logic       frame_tick
);

    localparam int unsigned CW = $clog2(MUTE_FRAMES + 2);

    // word periods closed since sync_ok rose
    logic [CW-1:0] settle_ticks;

    always_ff @(posedge clk) begin
        if (rst || !sync_ok)
            settle_ticks <= '0;
        else if (frame_tick && (settle_ticks != CW'(MUTE_FRAMES + 1)))
            settle_ticks <= settle_ticks + 1'b1;
    end

    a_r7_no_enable_unlocked: assert property (@(posedge clk) disable iff (rst)
        (ratio_code == 2'b11) |-> !en_256);

    a_r12_mute_when_unsynced: assert property (@(posedge clk) disable iff (rst)
        !sync_ok |-> mute_req);

    a_r11_muted_on_acquire: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_ok) |-> mute_req);

    a_r11_mute_window: assert property (@(posedge clk) disable iff (rst)
        $fell(mute_req) |-> (settle_ticks == CW'(MUTE_FRAMES)));

    a_r2_code_moves_on_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio_code) |-> $past(frame_tick));

    a_r9_loss_on_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_ok) |-> $past(frame_tick));

    a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
        (ratio_code == 2'b00) |-> en_256);

    a_r5_half_rate: assert property (@(posedge clk) disable iff (rst)
        (ratio_code == 2'b10 && en_256) |=> (!en_256 || ratio_code != 2'b10));

    a_r6_short_gap: assert property (@(posedge clk) disable iff (rst)
        (ratio_code == 2'b01 && !en_256) |=> (en_256 || ratio_code != 2'b01));

endmodule

bind clk_ratio_sync_mon crs_checker #(.MUTE_FRAMES(MUTE_FRAMES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ratio_code (ratio_code),
    .en_256     (en_256),
    .sync_ok    (sync_ok),
    .mute_req   (mute_req),
    .frame_tick (frame_tick)
);

// File: tb/clk_ratio_sync_mon_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_sync_mon_tb_top;

    localparam int WATCHDOG = 150000;

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic       wclk = 1'b0;
    logic       bclk = 1'b0;
    logic [1:0] ratio_code;
    logic       en_256;
    logic       sync_ok;
    logic       mute_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int en_cnt   = 0;
    int min_gap  = 0;
    int max_gap  = 0;
    int since    = 0;
    bit have_en  = 1'b0;

    always #2.5 clk = ~clk;

    clk_ratio_sync_mon dut_i (
        .clk        (clk),
        .rst        (rst),
        .wclk       (wclk),
        .bclk       (bclk),
        .ratio_code (ratio_code),
        .en_256     (en_256),
        .sync_ok    (sync_ok),
        .mute_req   (mute_req)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wclk = 1'b0; bclk = 1'b0; have_en = 1'b0; since = 0;
        repeat (4) @(negedge clk);
        chk("R1 ratio_code", int'(ratio_code), 3);
        chk("R1 en_256", int'(en_256), 0);
        chk("R1 sync_ok", int'(sync_ok), 0);
        chk("R1 mute_req", int'(mute_req), 1);
        rst = 1'b0;
    endtask

    // One word period of p system clocks carrying b bit-clock pulses
    task automatic run_frame(input int p, input int b);
        en_cnt = 0; min_gap = 1000; max_gap = 0;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            since++;
            if (en_256) begin
                en_cnt++;
                if (have_en) begin
                    if (since < min_gap) min_gap = since;
                    if (since > max_gap) max_gap = since;
                end
                have_en = 1'b1;
                since = 0;
            end
            wclk = (i < p / 2);
            bclk = (i == 0) || (((i * b) / p) != (((i - 1) * b) / p));
        end
    endtask

    task automatic t_lock(input int p, input int code, input int gmin, input int gmax,
                          input string req);
        do_reset();
        run_frame(p, 64);
        run_frame(p, 64);
        chk("R3 no code after two edges", int'(ratio_code), 3);
        chk("R7 no enables while unlocked", en_cnt, 0);
        run_frame(p, 64);
        chk("R2/R3 code at third edge", int'(ratio_code), code);
        chk("R11 sync_ok on acquire", int'(sync_ok), 1);
        chk("R11 mute held on acquire", int'(mute_req), 1);
        run_frame(p, 64);
        run_frame(p, 64);
        chk("R4 enables per period", en_cnt, 256);
        chk({req, " min gap"}, min_gap, gmin);
        chk({req, " max gap"}, max_gap, gmax);
    endtask

    task automatic t_tolerance();
        do_reset();
        repeat (3) run_frame(258, 64);
        chk("R2 period 258 accepted", int'(ratio_code), 0);
        do_reset();
        repeat (5) run_frame(259, 64);
        chk("R2 period 259 rejected", int'(ratio_code), 3);
        chk("R7 enables with 259", en_cnt, 0);
        chk("R12 sync_ok with 259", int'(sync_ok), 0);
        chk("R12 mute with 259", int'(mute_req), 1);
    endtask

    // Called right after the period in which sync_ok rose
    task automatic settle_window(input string tag);
        for (int k = 1; k <= 32; k++) begin
            run_frame(256, 64);
            chk({"R11 mute window ", tag}, int'(mute_req), (k < 32) ? 1 : 0);
            chk({"R11 sync held ", tag}, int'(sync_ok), 1);
        end
    endtask

    task automatic t_drift();
        do_reset();
        repeat (3) run_frame(256, 64);
        chk("R11 acquired", int'(sync_ok), 1);
        settle_window("first");
        run_frame(256, 68);
        run_frame(256, 64);
        chk("R8 drift 4 sync", int'(sync_ok), 1);
        run_frame(256, 64);
        chk("R8 drift 4 mute", int'(mute_req), 0);
        run_frame(256, 70);
        run_frame(256, 64);
        chk("R8 drift 6 sync", int'(sync_ok), 1);
        run_frame(256, 64);
        chk("R8 drift 6 mute", int'(mute_req), 0);
        run_frame(256, 71);
        chk("R9 not judged before edge", int'(sync_ok), 1);
        run_frame(256, 64);
        chk("R9 drift 7 sync lost", int'(sync_ok), 0);
        chk("R9 drift 7 mute", int'(mute_req), 1);
        chk("R9 ratio kept", int'(ratio_code), 0);
        run_frame(256, 64);
        chk("R9 still lost", int'(sync_ok), 0);
        run_frame(256, 64);
        chk("R11 reacquired", int'(sync_ok), 1);
        chk("R11 mute on reacquire", int'(mute_req), 1);
        settle_window("resync");
    endtask

    task automatic t_glitch();
        run_frame(300, 64);
        run_frame(256, 64);
        chk("R10 glitch ratio", int'(ratio_code), 3);
        chk("R10 glitch sync", int'(sync_ok), 0);
        chk("R12 glitch mute", int'(mute_req), 1);
        chk("R7 glitch enable", int'(en_256), 0);
        run_frame(256, 64);
        chk("R10 no relock yet", int'(ratio_code), 3);
        run_frame(256, 64);
        chk("R10 relock 256", int'(ratio_code), 0);
        chk("R10 sync back", int'(sync_ok), 1);
    endtask

    task automatic t_switch();
        run_frame(512, 64);
        chk("R10 old ratio kept", int'(ratio_code), 0);
        run_frame(512, 64);
        chk("R10 ratio dropped", int'(ratio_code), 3);
        chk("R10 switch sync", int'(sync_ok), 0);
        run_frame(512, 64);
        chk("R10 new ratio 512", int'(ratio_code), 2);
        run_frame(512, 64);
        chk("R5 enables per period", en_cnt, 256);
    endtask

    initial begin
        t_lock(256, 0, 1, 1, "R4");
        t_lock(384, 1, 1, 2, "R6");
        t_lock(512, 2, 2, 2, "R5");
        t_tolerance();
        t_drift();
        t_glitch();
        t_switch();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule